// File: doc/BRIEF.md
# Windowed Command and Status Port

This block is the host-side control port of a packet network controller. The host writes 16-bit command words to it. Each word carries an opcode in its upper five bits and an argument in its lower eleven bits. The host reads back one 16-bit status word, which reports the selected register window, the busy flag, the pending event bits and the interrupt latch. The block also holds the settings that the rest of the controller consumes:
- the interrupt mask,
- the receive address filter,
- the three FIFO thresholds,
- the transmitter and receiver enables.

The transmit and receive paths report events on single-cycle input pulses, and these set pending bits. The host clears pending bits with an acknowledge command. A single interrupt output is raised while any pending bit is also enabled in the mask.

A small sequencer has two states. In `ST_READY` every command is accepted. A global-reset command in `ST_READY` takes the transition `ST_READY -> ST_HOLD`. In that same cycle it returns all command state to its power-up values. `ST_HOLD` lasts `RST_HOLD` cycles. During that time the busy bit is reported, and commands and event pulses are dropped. When the hold counter reaches zero, the transition `ST_HOLD -> ST_READY` re-opens the port.

Top module: `cmdp_top`

## Requirements
- R1: A command word is decoded as opcode = bits 15:11 and argument = bits 10:0. An opcode outside the defined set (0x00, 0x01, 0x03, 0x04, 0x09, 0x0A, 0x0C, 0x0D, 0x0E, 0x10, 0x11, 0x12, 0x13) changes no state and no output.
- R2: Opcode 0x01 selects the window given by argument bits 2:0, and the upper argument bits are ignored. The selected window is reported in status bits 15:13 from the cycle after the write.
- R3: The status word has this layout:

  | Bit(s) | Meaning |
  |---|---|
  | 0 | interrupt latch |
  | 1 | adapter failure |
  | 2 | transmit complete |
  | 3 | transmit space available |
  | 4 | receive complete |
  | 5 | receive early |
  | 6 | interrupt requested |
  | 7 | statistics update |
  | 11:8 | read as zero |
  | 12 | command in progress (busy) |
  | 15:13 | selected window |

- R4: An event pulse sets its pending bit one cycle later. The bit stays set until it is acknowledged. A set and an acknowledge of the same bit in the same cycle leave the bit set.
- R5: Opcode 0x0D clears each pending bit 7:1 whose argument bit is one. Argument bit 0 clears the interrupt latch.
- R6: Opcode 0x0E loads the interrupt mask from argument bits 7:0. The irq output is high exactly when (pending bits 7:1 AND mask bits 7:1) is non-zero.
- R7: The interrupt latch is set when a newly arriving event, or a request made by opcode 0x0C, has its mask bit set. A pending bit that is already set does not set the latch when it is later unmasked.
- R8: Opcode 0x0C sets pending bit 6 (interrupt requested).
- R9: Opcode 0x10 loads the receive filter from argument bits 3:0:

  | Bit | Accepts |
  |---|---|
  | 0 | own address |
  | 1 | multicast |
  | 2 | broadcast |
  | 3 | all frames |

- R10: Opcodes 0x11, 0x12 and 0x13 load the receive-early, transmit-available and transmit-start thresholds. A value of 2047 turns the threshold off:
  - a receive-early threshold of 2047 stops the receive-early pulse from setting bit 5;
  - a transmit-available threshold of 2047 stops the transmit-available pulse from setting bit 3;
  - a transmit-start threshold of 2047 drives txs_active low.

  All three thresholds reset to 2047.
- R11: Opcode 0x00 returns window, mask, pending bits, latch, filter, thresholds and enables to their reset values, and sets status bit 12 for RST_HOLD cycles. While bit 12 is set, commands and event pulses have no effect. Event pulses that arrive in the same cycle as the reset command are also dropped.
- R12: Opcode 0x04 / 0x03 turn the receiver on / off, and 0x09 / 0x0A turn the transmitter on / off. Both are off after reset.
- R13: After hardware reset the status word is 0, irq is 0, the filter is 0 and all thresholds are 2047.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| cmd_wr | input | 1 | command write strobe |
| cmd_word | input | 16 | command word (opcode 15:11, argument 10:0) |
| ev_fail | input | 1 | adapter failure event pulse |
| ev_tx_done | input | 1 | transmit complete event pulse |
| ev_tx_room | input | 1 | transmit space available event pulse |
| ev_rx_done | input | 1 | receive complete event pulse |
| ev_rx_early | input | 1 | receive early event pulse |
| ev_stats | input | 1 | statistics update event pulse |
| status_word | output | 16 | status word |
| irq | output | 1 | interrupt request |
| rx_enable | output | 1 | receiver enabled |
| tx_enable | output | 1 | transmitter enabled |
| rx_filter | output | 4 | receive filter setting |
| rxe_thresh | output | 11 | receive-early threshold |
| txa_thresh | output | 11 | transmit-available threshold |
| txs_thresh | output | 11 | transmit-start threshold |
| txs_active | output | 1 | transmit-start threshold in use |

## Verification
Every register in this block feeds a port directly, so any wrong internal state shows on the cycle after the edge that stored it:
- A wrong window shows in status bits 15:13.
- A wrong pending bit or latch shows in the low status byte.
- A mask error shows as a wrong irq level.

A hold counter that is off by one shows as bit 12 clearing one cycle early or late, and as a command that is accepted or dropped at the boundary. The bench therefore compares the full status word and every setting output after each single clock edge. It compares them against a requirement-level model.

// File: rtl/cmdp_pkg.sv
package cmdp_pkg;

    localparam int CMD_W  = 16;
    localparam int OP_W   = 5;
    localparam int ARG_W  = CMD_W - OP_W;
    localparam int WIN_W  = 3;
    localparam int FILT_W = 4;

    localparam logic [ARG_W-1:0] THR_OFF = '1;

    localparam int EVB_FAIL  = 1;
    localparam int EVB_TXC   = 2;
    localparam int EVB_TXA   = 3;
    localparam int EVB_RXC   = 4;
    localparam int EVB_RXE   = 5;
    localparam int EVB_REQ   = 6;
    localparam int EVB_STATS = 7;

    typedef enum logic [OP_W-1:0] {
        OP_GLOBAL_RESET = 5'h00,
        OP_WINDOW       = 5'h01,
        OP_RX_OFF       = 5'h03,
        OP_RX_ON        = 5'h04,
        OP_TX_ON        = 5'h09,
        OP_TX_OFF       = 5'h0A,
        OP_REQ_INT      = 5'h0C,
        OP_ACK          = 5'h0D,
        OP_MASK         = 5'h0E,
        OP_FILTER       = 5'h10,
        OP_RXE_THR      = 5'h11,
        OP_TXA_THR      = 5'h12,
        OP_TXS_THR      = 5'h13
    } opcode_e;

    typedef enum logic [0:0] {
        ST_READY = 1'b0,
        ST_HOLD  = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic             glb_rst;
        logic             win_sel;
        logic             rx_on;
        logic             rx_off;
        logic             tx_on;
        logic             tx_off;
        logic             req_int;
        logic             ack;
        logic             mask_ld;
        logic             filt_ld;
        logic             rxe_ld;
        logic             txa_ld;
        logic             txs_ld;
        logic [ARG_W-1:0] arg;
    } cmd_dec_t;

endpackage

// File: rtl/cmdp_decode.sv
module cmdp_decode
    import cmdp_pkg::*;
(
    input  logic             wr,
    input  logic [CMD_W-1:0] word,
    input  logic             accept,
    output cmd_dec_t         dec
);

    always_comb begin
        dec     = '0;
        dec.arg = word[ARG_W-1:0];
        if (wr && accept) begin
            case (opcode_e'(word[CMD_W-1:ARG_W]))
                OP_GLOBAL_RESET: dec.glb_rst = 1'b1;
                OP_WINDOW:       dec.win_sel = 1'b1;
                OP_RX_OFF:       dec.rx_off  = 1'b1;
                OP_RX_ON:        dec.rx_on   = 1'b1;
                OP_TX_ON:        dec.tx_on   = 1'b1;
                OP_TX_OFF:       dec.tx_off  = 1'b1;
                OP_REQ_INT:      dec.req_int = 1'b1;
                OP_ACK:          dec.ack     = 1'b1;
                OP_MASK:         dec.mask_ld = 1'b1;
                OP_FILTER:       dec.filt_ld = 1'b1;
                OP_RXE_THR:      dec.rxe_ld  = 1'b1;
                OP_TXA_THR:      dec.txa_ld  = 1'b1;
                OP_TXS_THR:      dec.txs_ld  = 1'b1;
                default:         ;
            endcase
        end
    end

endmodule

// File: rtl/cmdp_seq.sv
module cmdp_seq
    import cmdp_pkg::*;
#(
    parameter int RST_HOLD = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic glb_rst,
    output logic accept,
    output logic busy
);

    localparam int CNT_W = (RST_HOLD < 2) ? 1 : $clog2(RST_HOLD);
    localparam logic [CNT_W-1:0] HOLD_LOAD = CNT_W'(RST_HOLD - 1);

    seq_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_READY: if (glb_rst)      state_d = ST_HOLD;
            ST_HOLD:  if (cnt_q == '0)  state_d = ST_READY;
            default:                    state_d = ST_READY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_READY;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_READY && glb_rst)
                cnt_q <= HOLD_LOAD;
            else if (state_q == ST_HOLD && cnt_q != '0)
                cnt_q <= cnt_q - 1'b1;
        end
    end

    always_comb begin
        accept = 1'b0;
        busy   = 1'b0;
        unique case (state_q)
            ST_READY: accept = 1'b1;
            ST_HOLD:  busy   = 1'b1;
            default:  ;
        endcase
    end

    AST_HOLD_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        glb_rst |=> busy && !accept); // R11
    AST_HOLD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= HOLD_LOAD); // R11
    AST_HOLD_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt_q == '0) |=> accept); // R11

endmodule

// File: rtl/cmdp_events.sv
module cmdp_events
    import cmdp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       frozen,
    input  logic [7:1] ev_raw,
    input  logic       rxe_off,
    input  logic       txa_off,
    input  logic       req_int,
    input  logic       ack,
    input  logic       mask_ld,
    input  logic [7:0] arg,
    output logic [7:1] pend,
    output logic       latch,
    output logic [7:0] mask,
    output logic       irq
);

    logic [7:1] new_ev;
    logic [7:1] ack_clr;
    logic       ack_latch;

    always_comb begin
        new_ev = '0;
        if (!frozen) begin
            new_ev          = ev_raw;
            new_ev[EVB_REQ] = req_int;
            if (rxe_off) new_ev[EVB_RXE] = 1'b0;
            if (txa_off) new_ev[EVB_TXA] = 1'b0;
        end
        ack_clr   = ack ? arg[7:1] : '0;
        ack_latch = ack && arg[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend  <= '0;
            latch <= 1'b0;
            mask  <= '0;
        end else if (clr) begin
            pend  <= '0;
            latch <= 1'b0;
            mask  <= '0;
        end else begin
            pend  <= (pend & ~ack_clr) | new_ev;
            latch <= (latch & ~ack_latch) | (|(new_ev & mask[7:1]));
            if (mask_ld) mask <= arg;
        end
    end

    assign irq = |(pend & mask[7:1]);

    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (pend != '0)); // R6
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && new_ev == '0 && !clr) |=> ((pend & $past(arg[7:1])) == '0)); // R5
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (new_ev != '0 && !clr) |=> ((pend & $past(new_ev)) == $past(new_ev))); // R4
    AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen && !ack && !mask_ld) |=> $stable(pend) && $stable(mask)); // R11

endmodule

// File: rtl/cmdp_config.sv
module cmdp_config
    import cmdp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  cmd_dec_t          dec,
    output logic [WIN_W-1:0]  win,
    output logic              rx_en,
    output logic              tx_en,
    output logic [FILT_W-1:0] filt,
    output logic [ARG_W-1:0]  rxe_thr,
    output logic [ARG_W-1:0]  txa_thr,
    output logic [ARG_W-1:0]  txs_thr
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win     <= '0;
            rx_en   <= 1'b0;
            tx_en   <= 1'b0;
            filt    <= '0;
            rxe_thr <= THR_OFF;
            txa_thr <= THR_OFF;
            txs_thr <= THR_OFF;
        end else if (dec.glb_rst) begin
            win     <= '0;
            rx_en   <= 1'b0;
            tx_en   <= 1'b0;
            filt    <= '0;
            rxe_thr <= THR_OFF;
            txa_thr <= THR_OFF;
            txs_thr <= THR_OFF;
        end else begin
            if (dec.win_sel) win <= dec.arg[WIN_W-1:0];
            if (dec.rx_on)   rx_en <= 1'b1;
            if (dec.rx_off)  rx_en <= 1'b0;
            if (dec.tx_on)   tx_en <= 1'b1;
            if (dec.tx_off)  tx_en <= 1'b0;
            if (dec.filt_ld) filt <= dec.arg[FILT_W-1:0];
            if (dec.rxe_ld)  rxe_thr <= dec.arg;
            if (dec.txa_ld)  txa_thr <= dec.arg;
            if (dec.txs_ld)  txs_thr <= dec.arg;
        end
    end

    AST_WIN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!dec.win_sel && !dec.glb_rst) |=> $stable(win)); // R2
    AST_ENABLES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        dec.glb_rst |=> !rx_en && !tx_en); // R12
    AST_THR_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        dec.glb_rst |=> (rxe_thr == THR_OFF) && (txa_thr == THR_OFF) && (txs_thr == THR_OFF)); // R10

endmodule

// File: rtl/cmdp_top.sv
module cmdp_top
    import cmdp_pkg::*;
#(
    parameter int RST_HOLD = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_wr,
    input  logic [15:0] cmd_word,
    input  logic        ev_fail,
    input  logic        ev_tx_done,
    input  logic        ev_tx_room,
    input  logic        ev_rx_done,
    input  logic        ev_rx_early,
    input  logic        ev_stats,
    output logic [15:0] status_word,
    output logic        irq,
    output logic        rx_enable,
    output logic        tx_enable,
    output logic [3:0]  rx_filter,
    output logic [10:0] rxe_thresh,
    output logic [10:0] txa_thresh,
    output logic [10:0] txs_thresh,
    output logic        txs_active
);

    cmd_dec_t         dec;
    logic             accept;
    logic             busy;
    logic [7:1]       ev_raw;
    logic [7:1]       pend;
    logic             latch;
    logic [7:0]       mask;
    logic [WIN_W-1:0] win;

    always_comb begin
        ev_raw            = '0;
        ev_raw[EVB_FAIL]  = ev_fail;
        ev_raw[EVB_TXC]   = ev_tx_done;
        ev_raw[EVB_TXA]   = ev_tx_room;
        ev_raw[EVB_RXC]   = ev_rx_done;
        ev_raw[EVB_RXE]   = ev_rx_early;
        ev_raw[EVB_STATS] = ev_stats;
    end

    cmdp_decode u_decode (
        .wr     (cmd_wr),
        .word   (cmd_word),
        .accept (accept),
        .dec    (dec)
    );

    cmdp_seq #(.RST_HOLD(RST_HOLD)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .glb_rst (dec.glb_rst),
        .accept  (accept),
        .busy    (busy)
    );

    cmdp_config u_config (
        .clk     (clk),
        .rst_n   (rst_n),
        .dec     (dec),
        .win     (win),
        .rx_en   (rx_enable),
        .tx_en   (tx_enable),
        .filt    (rx_filter),
        .rxe_thr (rxe_thresh),
        .txa_thr (txa_thresh),
        .txs_thr (txs_thresh)
    );

    cmdp_events u_events (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (dec.glb_rst),
        .frozen  (busy),
        .ev_raw  (ev_raw),
        .rxe_off (rxe_thresh == THR_OFF),
        .txa_off (txa_thresh == THR_OFF),
        .req_int (dec.req_int),
        .ack     (dec.ack),
        .mask_ld (dec.mask_ld),
        .arg     (dec.arg[7:0]),
        .pend    (pend),
        .latch   (latch),
        .mask    (mask),
        .irq     (irq)
    );

    assign txs_active  = (txs_thresh != THR_OFF);
    assign status_word = {win, busy, 4'b0000, pend, latch};

    AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !$past(dec.glb_rst)) |=> $stable(status_word[15:13])); // R11
    AST_ZERO_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        status_word[11:8] == 4'b0000); // R3

endmodule

// File: tb/tb_cmdp_top.sv
`timescale 1ns/1ps
module tb_cmdp_top;

    localparam int HOLD = 6;
    localparam logic [10:0] OFF = 11'd2047;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr = 1'b0;
    logic [15:0] cmd_word = '0;
    logic        ev_fail = 0, ev_tx_done = 0, ev_tx_room = 0;
    logic        ev_rx_done = 0, ev_rx_early = 0, ev_stats = 0;
    logic [15:0] status_word;
    logic        irq, rx_enable, tx_enable, txs_active;
    logic [3:0]  rx_filter;
    logic [10:0] rxe_thresh, txa_thresh, txs_thresh;

    always #2.5 clk = ~clk;

    cmdp_top #(.RST_HOLD(HOLD)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
        .ev_fail(ev_fail), .ev_tx_done(ev_tx_done), .ev_tx_room(ev_tx_room),
        .ev_rx_done(ev_rx_done), .ev_rx_early(ev_rx_early), .ev_stats(ev_stats),
        .status_word(status_word), .irq(irq), .rx_enable(rx_enable),
        .tx_enable(tx_enable), .rx_filter(rx_filter), .rxe_thresh(rxe_thresh),
        .txa_thresh(txa_thresh), .txs_thresh(txs_thresh), .txs_active(txs_active)
    );

    typedef struct {
        logic [15:0] st;
        logic        irq;
        logic        rxen, txen, txsa;
        logic [3:0]  filt;
        logic [10:0] rxe, txa, txs;
        string       tag;
    } exp_t;

    exp_t q[$];
    int total = 0;
    int bad = 0;
    bit finished = 0;

    // requirement-level model
    logic [2:0]  m_win;
    logic        m_busy;
    int          m_cnt;
    logic [7:1]  m_pend;
    logic        m_latch;
    logic [7:0]  m_mask;
    logic        m_rxen, m_txen;
    logic [3:0]  m_filt;
    logic [10:0] m_rxe, m_txa, m_txs;

    task automatic model_clear();
        m_win = 0; m_pend = 0; m_latch = 0; m_mask = 0;
        m_rxen = 0; m_txen = 0; m_filt = 0;
        m_rxe = OFF; m_txa = OFF; m_txs = OFF;
    endtask

    task automatic model_tick(input bit wr, input logic [4:0] op,
                              input logic [10:0] a, input logic [7:1] e);
        logic [7:1] nev;
        logic [7:1] clr;
        logic       l0;
        if (m_busy) begin
            if (m_cnt == 0) m_busy = 0; else m_cnt--;
            return;
        end
        if (wr && op == 5'h00) begin
            model_clear();
            m_busy = 1;
            m_cnt  = HOLD - 1;
            return;
        end
        nev = e;
        nev[6] = (wr && op == 5'h0C);
        if (m_rxe == OFF) nev[5] = 0;
        if (m_txa == OFF) nev[3] = 0;
        clr = (wr && op == 5'h0D) ? a[7:1] : '0;
        l0  = wr && op == 5'h0D && a[0];
        m_latch = (m_latch & ~l0) | (|(nev & m_mask[7:1]));
        m_pend  = (m_pend & ~clr) | nev;
        if (wr) begin
            case (op)
                5'h01: m_win = a[2:0];
                5'h03: m_rxen = 0;
                5'h04: m_rxen = 1;
                5'h09: m_txen = 1;
                5'h0A: m_txen = 0;
                5'h0E: m_mask = a[7:0];
                5'h10: m_filt = a[3:0];
                5'h11: m_rxe = a;
                5'h12: m_txa = a;
                5'h13: m_txs = a;
                default: ;
            endcase
        end
    endtask

    task automatic push_exp(input string tag);
        exp_t x;
        x.st   = {m_win, m_busy, 4'b0000, m_pend, m_latch};
        x.irq  = |(m_pend & m_mask[7:1]);
        x.rxen = m_rxen; x.txen = m_txen; x.txsa = (m_txs != OFF);
        x.filt = m_filt; x.rxe = m_rxe; x.txa = m_txa; x.txs = m_txs;
        x.tag  = tag;
        q.push_back(x);
    endtask

    // driver: one clock edge per step; e bits: 1 fail,2 txdone,3 txroom,4 rxdone,5 rxearly,7 stats
    task automatic step(input bit wr, input logic [4:0] op, input logic [10:0] a,
                        input logic [7:1] e, input string tag);
        cmd_wr      = wr;
        cmd_word    = {op, a};
        ev_fail     = e[1];
        ev_tx_done  = e[2];
        ev_tx_room  = e[3];
        ev_rx_done  = e[4];
        ev_rx_early = e[5];
        ev_stats    = e[7];
        @(posedge clk);
        #1;
        model_tick(wr, op, a, e);
        cmd_wr = 0; cmd_word = '0;
        ev_fail = 0; ev_tx_done = 0; ev_tx_room = 0;
        ev_rx_done = 0; ev_rx_early = 0; ev_stats = 0;
        push_exp(tag);
    endtask

    task automatic cmp(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // monitor
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t x;
            x = q.pop_front();
            cmp(x.tag, "status", status_word, x.st);
            cmp(x.tag, "irq", {15'b0, irq}, {15'b0, x.irq});
            cmp(x.tag, "enables", {13'b0, rx_enable, tx_enable, txs_active},
                {13'b0, x.rxen, x.txen, x.txsa});
            cmp(x.tag, "filter", {12'b0, rx_filter}, {12'b0, x.filt});
            cmp(x.tag, "rxe_thr", {5'b0, rxe_thresh}, {5'b0, x.rxe});
            cmp(x.tag, "txa_thr", {5'b0, txa_thresh}, {5'b0, x.txa});
            cmp(x.tag, "txs_thr", {5'b0, txs_thresh}, {5'b0, x.txs});
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 20000);
        total++; bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        model_clear();
        m_busy = 0; m_cnt = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        step(0, 5'h00, 0, 7'h00, "R13 reset state");
        step(1, 5'h01, 11'h7FD, 7'h00, "R2 window 5");
        step(1, 5'h02, 11'h3FF, 7'h00, "R1 undefined 0x02");
        step(1, 5'h1F, 11'h7FF, 7'h00, "R1 undefined 0x1F");
        step(1, 5'h05, 11'h0FF, 7'h00, "R1 undefined 0x05");
        step(0, 5'h00, 0, 7'b0001010, "R4 tx/rx done set");
        step(0, 5'h00, 0, 7'b1000001, "R3 fail and stats bits");
        step(1, 5'h0E, 11'h014, 7'h00, "R6 mask load irq");
        step(0, 5'h00, 0, 7'b0000100, "R7 unmasked event no latch");
        step(0, 5'h00, 0, 7'b0001000, "R7 masked event latches");
        step(1, 5'h0D, 11'h005, 7'h00, "R5 ack bit2 and latch");
        step(1, 5'h0D, 11'h010, 7'b0001000, "R4 set wins over ack");
        step(1, 5'h0D, 11'h0FF, 7'h00, "R5 ack all");
        step(1, 5'h0E, 11'h040, 7'h00, "R6 mask request only");
        step(1, 5'h0C, 11'h000, 7'h00, "R8 request interrupt");
        step(1, 5'h0D, 11'h041, 7'h00, "R5 ack request");
        step(1, 5'h10, 11'h7FA, 7'h00, "R9 filter load");
        step(0, 5'h00, 0, 7'b0010100, "R10 thresholds off drop early/room");
        step(1, 5'h11, 11'd100, 7'h00, "R10 rx early threshold");
        step(1, 5'h12, 11'd2047, 7'b0010100, "R10 rx early counts room dropped");
        step(1, 5'h13, 11'd20, 7'h00, "R10 tx start on");
        step(1, 5'h12, 11'd64, 7'h00, "R10 tx avail threshold");
        step(0, 5'h00, 0, 7'b0000100, "R10 tx room counts");
        step(1, 5'h13, 11'd2047, 7'h00, "R10 tx start off");
        step(1, 5'h04, 0, 7'h00, "R12 rx on");
        step(1, 5'h09, 0, 7'h00, "R12 tx on");
        step(1, 5'h03, 0, 7'h00, "R12 rx off");
        step(1, 5'h01, 11'h003, 7'h00, "R2 window 3");
        step(1, 5'h0E, 11'h0FE, 7'h00, "R6 mask all");
        step(1, 5'h00, 0, 7'b1011111, "R11 global reset drops events");
        for (int i = 0; i < HOLD + 2; i++) begin
            if (i % 2 == 0)
                step(1, 5'h01, 11'h007, 7'b0001000, "R11 hold ignores command");
            else
                step(1, 5'h04, 0, 7'b0000010, "R11 hold ignores command");
        end
        step(1, 5'h01, 11'h006, 7'h00, "R11 accepted after hold");
        step(0, 5'h00, 0, 7'b0000010, "R11 events after hold");
        step(0, 5'h00, 0, 7'h00, "R3 idle");
        repeat (2) @(posedge clk);
        finish_run();
    end

endmodule